// File: doc/BRIEF.md
# Lane-Partitioned Saturating Adder/Subtractor

This block is a 64-bit combinational adder/subtractor whose carry chain can be cut into independent signed lanes. A two-bit size select picks eight 8-bit lanes, four 16-bit lanes, two 32-bit lanes or a single 64-bit lane. Every lane adds or subtracts its own slices of the two operands, and no carry ever crosses into the next lane.

Each lane detects signed overflow for itself. With saturation off, a lane wraps modulo its width. With saturation on, a lane that overflows is clamped to its most positive or most negative signed value, chosen by the direction of the overflow. Lanes that do not overflow are unaffected. One overflow flag per lane comes out on an 8-bit vector. A flag sits at the position of the top byte of its lane.

The block is intended for a media datapath, where clipping audio samples or pixel values is cheaper than wrapping them.

Top module: `simd_sat_adder`

## Requirements
- R1: `laneSize` selects the lane width: 2'b00 gives 8-bit lanes, 2'b01 gives 16-bit lanes, 2'b10 gives 32-bit lanes. Lane n occupies bits [n*w+w-1 : n*w] of each operand and of the result.
- R2: The carry into the least significant bit of every lane equals `subtract`. No carry from one lane reaches the lane above it.
- R3: With `subtract`=0 and `saturate`=0, each lane of `result` is (a + b) mod 2^w.
- R4: With `subtract`=1, each lane computes a + ~b + 1, which is (a - b) mod 2^w when `saturate`=0.
- R5: A lane's overflow is set when:
  - for an add, both operands have the same sign and the wrapped result has the other sign;
  - for a subtract, the operand signs differ and the wrapped result's sign differs from that of the first operand.
- R6: `laneOvf[k]` holds the overflow of the lane whose top byte is byte k, meaning the lane ending at bit 8k+7. Every bit at a position that is not a lane's top byte reads 0.
- R7: With `saturate`=1, an overflowing lane whose first operand is non-negative becomes the lane's maximum signed value (0 followed by ones). An overflowing lane whose first operand is negative becomes the minimum (1 followed by zeros).
- R8: With `saturate`=1, a lane without overflow carries the same value it would carry with `saturate`=0.
- R9: `laneSize`=2'b11 treats the whole 64-bit word as one lane, and its flag appears on `laneOvf[7]`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| opA | input | 64 | First operand, packed lanes |
| opB | input | 64 | Second operand, packed lanes |
| laneSize | input | 2 | Lane width select (00=8, 01=16, 10=32, 11=64 bits) |
| subtract | input | 1 | 1 selects opA - opB, 0 selects opA + opB |
| saturate | input | 1 | 1 clamps overflowing lanes, 0 wraps them |
| result | output | 64 | Packed per-lane result |
| laneOvf | output | 8 | Per-lane overflow, at the top byte position of each lane |

## Verification
The bench builds the block with its default parameters: eight slices of 8 bits each. With these values all four lane configurations can be reached, including the full 64-bit lane, and every lane boundary where the carry is cut lies at a byte edge that a directed vector can straddle. Directed vectors push carries across each boundary, and they drive each lane to its positive and negative overflow in both operations. Random operands then sweep every combination of size, operation and saturation against the behavioural model.

// File: rtl/psa_pkg.sv
package psa_pkg;
  localparam int SLICE_W    = 8;
  localparam int NUM_SLICES = 8;
  localparam int WORD_W     = SLICE_W * NUM_SLICES;

  // Strobes passed from the lane control to the datapath
  typedef struct packed {
    logic [NUM_SLICES-1:0] cutMask;  // slice k starts a lane
    logic [NUM_SLICES-1:0] topMask;  // slice k ends a lane
    logic                  carryIn;  // injected carry at each cut
    logic                  satEn;    // clamp instead of wrap
  } laneStrobes_t;
endpackage

// File: rtl/psa_ctrl.sv
module psa_ctrl
  import psa_pkg::*;
(
  input  logic [1:0]   laneSize,
  input  logic         subtract,
  input  logic         saturate,
  output laneStrobes_t strobes
);
  always_comb begin
    int spanMask;
    spanMask = (1 << laneSize) - 1;
    if (spanMask > NUM_SLICES - 1) spanMask = NUM_SLICES - 1;
    strobes.carryIn = subtract;
    strobes.satEn   = saturate;
    for (int k = 0; k < NUM_SLICES; k++) begin
      strobes.cutMask[k] = ((k & spanMask) == 0);
      strobes.topMask[k] = ((k & spanMask) == spanMask);
    end
  end

  always_comb begin
    assert_base_cut_R2: assert (strobes.cutMask[0]);
    assert_top_end_R6: assert (strobes.topMask[NUM_SLICES-1]);
    assert_mask_pairs_R1: assert ($countones(strobes.cutMask) == $countones(strobes.topMask));
  end
endmodule

// File: rtl/psa_slice.sv
module psa_slice #(
  parameter int W = 8
) (
  input  logic [W-1:0] a,
  input  logic [W-1:0] b,
  input  logic         sub,
  input  logic         cin,
  output logic [W-1:0] raw,
  output logic         cout,
  output logic         ovf
);
  logic [W-1:0] bEff;
  always_comb begin
    bEff        = b ^ {W{sub}};
    {cout, raw} = {1'b0, a} + {1'b0, bEff} + {{W{1'b0}}, cin};
    ovf         = (a[W-1] == bEff[W-1]) && (raw[W-1] != a[W-1]);
  end
endmodule

// File: rtl/psa_datapath.sv
module psa_datapath
  import psa_pkg::*;
(
  input  logic [WORD_W-1:0]     opA,
  input  logic [WORD_W-1:0]     opB,
  input  laneStrobes_t          strobes,
  output logic [WORD_W-1:0]     result,
  output logic [NUM_SLICES-1:0] laneOvf
);
  logic [NUM_SLICES-1:0] sliceCin, sliceCout, sliceOvf, laneOvfB, laneNegB;
  logic [SLICE_W-1:0]    sliceRaw [NUM_SLICES];

  for (genvar k = 0; k < NUM_SLICES; k++) begin : g_slice
    if (k == 0) begin : g_first
      assign sliceCin[k] = strobes.carryIn;
    end else begin : g_rest
      assign sliceCin[k] = strobes.cutMask[k] ? strobes.carryIn : sliceCout[k-1];
    end

    psa_slice #(.W(SLICE_W)) u_slice (
      .a   (opA[k*SLICE_W +: SLICE_W]),
      .b   (opB[k*SLICE_W +: SLICE_W]),
      .sub (strobes.carryIn),
      .cin (sliceCin[k]),
      .raw (sliceRaw[k]),
      .cout(sliceCout[k]),
      .ovf (sliceOvf[k])
    );

    // overflow and sign of the lane's top slice, passed down through the lane
    if (k == NUM_SLICES - 1) begin : g_top
      assign laneOvfB[k] = sliceOvf[k];
      assign laneNegB[k] = opA[k*SLICE_W + SLICE_W - 1];
    end else begin : g_inner
      assign laneOvfB[k] = strobes.topMask[k] ? sliceOvf[k] : laneOvfB[k+1];
      assign laneNegB[k] = strobes.topMask[k] ? opA[k*SLICE_W + SLICE_W - 1] : laneNegB[k+1];
    end

    always_comb begin
      if (strobes.satEn && laneOvfB[k]) begin
        if (strobes.topMask[k])
          result[k*SLICE_W +: SLICE_W] = {laneNegB[k], {(SLICE_W-1){~laneNegB[k]}}};
        else
          result[k*SLICE_W +: SLICE_W] = {SLICE_W{~laneNegB[k]}};
      end else begin
        result[k*SLICE_W +: SLICE_W] = sliceRaw[k];
      end
    end
  end

  assign laneOvf = sliceOvf & strobes.topMask;

  always_comb begin
    // a - a wraps through zero: every lane's top slice carries out
    if (strobes.carryIn && opA == opB)
      assert_self_sub_carry_R4: assert (sliceCout[NUM_SLICES-1] && laneOvf == '0);
  end
endmodule

// File: rtl/simd_sat_adder.sv
module simd_sat_adder
  import psa_pkg::*;
(
  input  logic [63:0] opA,
  input  logic [63:0] opB,
  input  logic [1:0]  laneSize,
  input  logic        subtract,
  input  logic        saturate,
  output logic [63:0] result,
  output logic [7:0]  laneOvf
);
  laneStrobes_t strobes;

  psa_ctrl u_ctrl (
    .laneSize(laneSize),
    .subtract(subtract),
    .saturate(saturate),
    .strobes (strobes)
  );

  psa_datapath u_dp (
    .opA    (opA),
    .opB    (opB),
    .strobes(strobes),
    .result (result),
    .laneOvf(laneOvf)
  );

  always_comb begin
    assert_flag_count_R6: assert ($countones(laneOvf) <= (NUM_SLICES >> laneSize));
    for (int k = 0; k < NUM_SLICES; k++) begin
      if (laneOvf[k] && !saturate)
        assert_wrap_sign_R5: assert (result[k*SLICE_W+SLICE_W-1] != opA[k*SLICE_W+SLICE_W-1]);
      if (laneOvf[k] && saturate)
        assert_clamp_sign_R7: assert (result[k*SLICE_W+SLICE_W-1] == opA[k*SLICE_W+SLICE_W-1]);
    end
  end
endmodule

// File: tb/simd_sat_adder_test.sv
module simd_sat_adder_test;
  logic clk = 1'b0;
  always #5 clk = ~clk;

  logic [63:0] opA = '0, opB = '0;
  logic [1:0]  laneSize = 2'b00;
  logic        subtract = 1'b0, saturate = 1'b0;
  logic [63:0] result;
  logic [7:0]  laneOvf;

  int applied = 0;
  int miscompares = 0;
  bit finished = 0;

  simd_sat_adder uut (
    .opA(opA), .opB(opB), .laneSize(laneSize),
    .subtract(subtract), .saturate(saturate),
    .result(result), .laneOvf(laneOvf)
  );

  // behavioural lane-by-lane reference
  function automatic void model(input logic [63:0] a, input logic [63:0] b,
                                input logic [1:0] ls, input logic sub, input logic sat,
                                output logic [63:0] s, output logic [7:0] f);
    int w = 8 << ls;
    int lanes = 64 / w;
    logic [63:0] mask = (w == 64) ? 64'hFFFF_FFFF_FFFF_FFFF : ((64'd1 << w) - 64'd1);
    s = '0; f = '0;
    for (int n = 0; n < lanes; n++) begin
      logic [63:0] ax, bx, bn, r;
      logic sa, sb, sr, ov;
      ax = (a >> (n*w)) & mask;
      bx = (b >> (n*w)) & mask;
      bn = sub ? (~bx & mask) : bx;
      r  = (ax + bn + {63'd0, sub}) & mask;
      sa = ax[w-1]; sb = bn[w-1]; sr = r[w-1];
      ov = (sa == sb) && (sr != sa);
      if (sat && ov) r = sa ? (64'd1 << (w-1)) : (mask >> 1);
      s |= r << (n*w);
      f[n*(w/8) + w/8 - 1] = ov;
    end
  endfunction

  task automatic apply(input logic [63:0] a, input logic [63:0] b,
                       input logic [1:0] ls, input logic sub, input logic sat,
                       input string tag);
    logic [63:0] es; logic [7:0] ef; string t;
    @(posedge clk); #1;
    opA = a; opB = b; laneSize = ls; subtract = sub; saturate = sat;
    model(a, b, ls, sub, sat, es, ef);
    @(negedge clk);
    applied++;
    if (result !== es) begin
      miscompares++;
      t = tag;
      if (tag == "") t = (sat && ef != 0) ? "R7" : sat ? "R8" : (ls == 2'b11) ? "R9" : sub ? "R4" : "R3";
      $display("FAIL %s result ls=%0d sub=%0b sat=%0b actual=%h expected=%h", t, ls, sub, sat, result, es);
    end
    if (laneOvf !== ef) begin
      miscompares++;
      t = ((laneOvf & ~ef) != 0 && ef == 0) ? "R6" : "R5";
      $display("FAIL %s laneOvf ls=%0d sub=%0b actual=%b expected=%b", t, ls, sub, laneOvf, ef);
    end
  endtask

  initial begin
    // idle state: zero operands give zero result and no flags
    apply(64'd0, 64'd0, 2'b00, 1'b0, 1'b0, "R3");
    // R1 / R2: carries stop at every lane boundary in each size
    apply(64'h00FF_00FF_00FF_00FF, 64'h0001_0001_0001_0001, 2'b00, 1'b0, 1'b0, "R2");
    apply(64'h00FF_00FF_00FF_00FF, 64'h0001_0001_0001_0001, 2'b01, 1'b0, 1'b0, "R1");
    apply(64'h0000_FFFF_0000_FFFF, 64'h0000_0001_0000_0001, 2'b01, 1'b0, 1'b0, "R2");
    apply(64'h0000_FFFF_0000_FFFF, 64'h0000_0001_0000_0001, 2'b10, 1'b0, 1'b0, "R1");
    apply(64'h0000_0000_FFFF_FFFF, 64'h0000_0000_0000_0001, 2'b10, 1'b0, 1'b0, "R2");
    // R4: subtract borrows stay inside lanes
    apply(64'h0000_0000_0000_0000, 64'h0101_0101_0101_0101, 2'b00, 1'b1, 1'b0, "R4");
    apply(64'h1234_5678_9ABC_DEF0, 64'h1234_5678_9ABC_DEF0, 2'b01, 1'b1, 1'b0, "R4");
    // R5 / R6: add and subtract overflow in every lane size, wrapping
    apply(64'h7F80_7F80_7F80_7F80, 64'h0180_0180_0180_0180, 2'b00, 1'b0, 1'b0, "R5");
    apply(64'h7FFF_8000_7FFF_8000, 64'h0001_0001_FFFF_FFFF, 2'b01, 1'b1, 1'b0, "R6");
    apply(64'h7FFF_FFFF_8000_0000, 64'h0000_0001_FFFF_FFFF, 2'b10, 1'b0, 1'b0, "R5");
    // R7: clamps to max and min
    apply(64'h7F80_7F80_7F80_7F80, 64'h0180_0180_0180_0180, 2'b00, 1'b0, 1'b1, "R7");
    apply(64'h7FFF_8000_7FFF_8000, 64'h8000_0001_FFFF_0001, 2'b01, 1'b1, 1'b1, "R7");
    apply(64'h7FFF_FFFF_8000_0000, 64'h0000_0001_0000_0001, 2'b10, 1'b1, 1'b1, "R7");
    // R8: saturate on, no overflow, wrap-equivalent result
    apply(64'h1020_3040_5060_7000, 64'h0102_0304_0506_0708, 2'b00, 1'b0, 1'b1, "R8");
    // R9: single 64-bit lane
    apply(64'h7FFF_FFFF_FFFF_FFFF, 64'h0000_0000_0000_0001, 2'b11, 1'b0, 1'b0, "R9");
    apply(64'h8000_0000_0000_0000, 64'h0000_0000_0000_0001, 2'b11, 1'b1, 1'b1, "R9");
    apply(64'h0000_0000_FFFF_FFFF, 64'h0000_0000_0000_0001, 2'b11, 1'b0, 1'b0, "R9");
    // random sweep over all modes
    for (int i = 0; i < 3000; i++) begin
      logic [63:0] ra, rb;
      ra = {$urandom, $urandom};
      rb = {$urandom, $urandom};
      if (i % 4 == 1) rb = ra ^ 64'h8080_8080_8080_8080;
      if (i % 4 == 2) ra = ra | 64'h7070_7070_7070_7070;
      apply(ra, rb, 2'(i % 4), 1'((i / 4) % 2), 1'((i / 8) % 2), "");
    end
    finished = 1;
    $display("== %0d vectors applied, %0d miscompares ==", applied, miscompares);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      miscompares++;
      $display("FAIL watchdog expired actual=running expected=done");
      $display("== %0d vectors applied, %0d miscompares ==", applied, miscompares);
      $finish;
    end
  end
endmodule